// File: doc/BRIEF.md
# Dual-Convention Host Bus Interface

This block sits between an external microprocessor bus and the internal RAM and register ports. Four static strap inputs set how the pins are read. One chooses between separate read/write strobes and a data strobe paired with a read/not-write line. One sets the data strobe polarity. One sets an 8-bit or 16-bit data path. One chooses a plain address bus or an address multiplexed onto the data pins and captured by two byte latch enables.

The chip selects are decoded into a RAM target or a register target. Each leading edge of an external strobe is brought into the internal clock domain and becomes exactly one single-cycle internal read or write strobe. That strobe carries a word address, byte enables and steered write data. On reads, the block steers the selected internal word onto the correct data lanes. It also produces per-lane output enables for the data pins and an output enable for the latched address. The tri-state drivers themselves sit outside the block.

Top module: `host_bus_if`

## Requirements
- R1: With `mode_moto_i`=0, a low `strb_a_i` is a read and a low `strb_b_i` is a write.
- R2: With `mode_moto_i`=1, `strb_a_i` is a data strobe and `strb_b_i` is read/not-write: 1 means read and 0 means write.
- R3: In data-strobe mode, `ds_pol_i`=0 makes the strobe active low and `ds_pol_i`=1 makes it active high. In separate-strobe mode, `ds_pol_i` has no effect.
- R4: Each inactive-to-active strobe transition produces exactly one internal read or write pulse, lasting one clock cycle and appearing within four rising clock edges. Holding the strobe active produces no further pulse.
- R5: Both `mem_cs0_ni` and `mem_cs1_ni` low selects RAM. `per_cs_ni` low with `per_cs_i` high selects the registers. With neither selected, no pulse is issued. The RAM word address is address bits 10..1, and the register address is address bits 6..1.
- R6: With `mux_i`=1, the address is taken from `data_i`. Latch enable `ale_lo_i` is transparent for bits 7..0 while high and holds them while low. `ale_hi_i` does the same for bits 15..8. `addr_o` shows the latched address, `addr_oe_o` is 1, and `addr_i` is ignored.
- R7: With `mux_i`=0, the address comes from `addr_i` and `addr_oe_o` is 0.
- R8: With `wide_i`=1, `be_o[0]` = NOT A0 and `be_o[1]` = NOT `bhe_ni`. `wdata_o` equals `data_i`, and a read returns the full word on `data_o`.
- R9: With `wide_i`=0, A0=0 gives `be_o`=01 and A0=1 gives `be_o`=10. `wdata_o` carries `data_i[7:0]` in both bytes. A read returns the byte chosen by A0 on `data_o[7:0]`, with `data_o[15:8]`=0.
- R10: `data_oe_o` is nonzero only while a read strobe is active with a valid select. Lane 0 is enabled when the mode is narrow or A0=0. Lane 1 is enabled only when the mode is wide and `bhe_ni`=0.
- R11: After reset, all internal strobes are 0 and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_moto_i | input | 1 | Strap: 0 separate strobes, 1 data strobe plus read/not-write |
| ds_pol_i | input | 1 | Strap: data strobe polarity, 1 = active high |
| wide_i | input | 1 | Strap: 1 = 16-bit data path, 0 = 8-bit |
| mux_i | input | 1 | Strap: 1 = multiplexed address/data |
| strb_a_i | input | 1 | Read strobe or data strobe |
| strb_b_i | input | 1 | Write strobe or read/not-write |
| ale_lo_i | input | 1 | Low address byte latch enable |
| ale_hi_i | input | 1 | High address byte latch enable |
| addr_i | input | 16 | Address pins as inputs |
| addr_o | output | 16 | Latched address |
| addr_oe_o | output | 1 | Address pin drive enable |
| data_i | input | 16 | Data pins as inputs |
| data_o | output | 16 | Read data to pins |
| data_oe_o | output | 2 | Per-lane data pin drive enables |
| mem_cs0_ni | input | 1 | RAM select 0, active low |
| mem_cs1_ni | input | 1 | RAM select 1, active low |
| per_cs_ni | input | 1 | Register select, active low |
| per_cs_i | input | 1 | Register select, active high |
| bhe_ni | input | 1 | High byte enable, active low |
| ram_rd_o | output | 1 | Internal RAM read pulse |
| ram_wr_o | output | 1 | Internal RAM write pulse |
| ram_addr_o | output | 10 | RAM word address |
| reg_rd_o | output | 1 | Internal register read pulse |
| reg_wr_o | output | 1 | Internal register write pulse |
| reg_addr_o | output | 6 | Register address |
| be_o | output | 2 | Byte enables |
| wdata_o | output | 16 | Write data |
| ram_rdata_i | input | 16 | RAM read word |
| reg_rdata_i | input | 16 | Register read word |

## Verification
The assertions assume static straps and address, select and data pins that stay still while a strobe is active. In data-strobe mode, they also assume the read/not-write line changes only while the data strobe is inactive. The stimulus keeps to this rule. It sets the straps, selects and address first, then sets read/not-write for a write, and only then asserts the strobe. It holds everything until the strobe is released and the idle gap has passed. In multiplexed mode, the data bus changes only after both latch enables have fallen.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_RAM = 2'd1, TGT_REG = 2'd2} tgt_e;
endpackage

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode (
  input  logic mode_moto_i,
  input  logic ds_pol_i,
  input  logic strb_a_i,
  input  logic strb_b_i,
  output logic rd_act_o,
  output logic wr_act_o
);
  logic ds_act;
  always_comb begin
    ds_act = ds_pol_i ? strb_a_i : ~strb_a_i;
    if (mode_moto_i) begin
      rd_act_o = ds_act & strb_b_i;
      wr_act_o = ds_act & ~strb_b_i;
    end else begin
      rd_act_o = ~strb_a_i;
      wr_act_o = ~strb_b_i;
    end
  end
endmodule

// File: rtl/hbi_edge_sync.sv
module hbi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_i,
  input  logic          ale_lo_i,
  input  logic          ale_hi_i,
  input  logic [AW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] latch_o,
  output logic [AW-1:0] eff_addr_o
);
  localparam int unsigned LW = AW / 2;
  logic [LW-1:0]    lo_q;
  logic [AW-LW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (ale_lo_i) lo_q <= data_i[LW-1:0];
      if (ale_hi_i) hi_q <= data_i[AW-1:LW];
    end

  // transparent while enable high, hold while low
  assign latch_o[LW-1:0]  = ale_lo_i ? data_i[LW-1:0]  : lo_q;
  assign latch_o[AW-1:LW] = ale_hi_i ? data_i[AW-1:LW] : hi_q;
  assign eff_addr_o       = mux_i ? latch_o : addr_i;
endmodule

// File: rtl/hbi_lane_steer.sv
module hbi_lane_steer #(
  parameter int unsigned DW = 16
) (
  input  logic          wide_i,
  input  logic          a0_i,
  input  logic          bhe_ni,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rdata_i,
  output logic [1:0]    be_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rd_out_o,
  output logic [1:0]    lane_en_o
);
  localparam int unsigned BW = DW / 2;
  always_comb begin
    if (wide_i) begin
      be_o      = {~bhe_ni, ~a0_i};
      wdata_o   = data_i;
      rd_out_o  = rdata_i;
      lane_en_o = {~bhe_ni, ~a0_i};
    end else begin
      be_o      = a0_i ? 2'b10 : 2'b01;
      wdata_o   = {data_i[BW-1:0], data_i[BW-1:0]};
      rd_out_o  = {{BW{1'b0}}, (a0_i ? rdata_i[DW-1:BW] : rdata_i[BW-1:0])};
      lane_en_o = 2'b01;
    end
  end
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned RAM_AW      = 10,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_moto_i,
  input  logic              ds_pol_i,
  input  logic              wide_i,
  input  logic              mux_i,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic              ale_lo_i,
  input  logic              ale_hi_i,
  input  logic [AW-1:0]     addr_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_oe_o,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic [1:0]        data_oe_o,
  input  logic              mem_cs0_ni,
  input  logic              mem_cs1_ni,
  input  logic              per_cs_ni,
  input  logic              per_cs_i,
  input  logic              bhe_ni,
  output logic              ram_rd_o,
  output logic              ram_wr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [1:0]        be_o,
  output logic [DW-1:0]     wdata_o,
  input  logic [DW-1:0]     ram_rdata_i,
  input  logic [DW-1:0]     reg_rdata_i
);
  import hbi_pkg::*;

  logic rd_act, wr_act, rd_pulse, wr_pulse;
  logic [AW-1:0] eff_addr;
  logic [1:0]    be_c, lane_en;
  logic [DW-1:0] wdata_c, rd_out;
  tgt_e          tgt;

  hbi_strobe_decode u_dec (
    .mode_moto_i(mode_moto_i), .ds_pol_i(ds_pol_i),
    .strb_a_i(strb_a_i), .strb_b_i(strb_b_i),
    .rd_act_o(rd_act), .wr_act_o(wr_act)
  );

  hbi_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(rd_act), .pulse_o(rd_pulse)
  );
  hbi_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(wr_act), .pulse_o(wr_pulse)
  );

  hbi_addr_latch #(.AW(AW)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .mux_i(mux_i),
    .ale_lo_i(ale_lo_i), .ale_hi_i(ale_hi_i),
    .data_i(data_i), .addr_i(addr_i),
    .latch_o(addr_o), .eff_addr_o(eff_addr)
  );
  assign addr_oe_o = mux_i;

  always_comb begin
    if (!mem_cs0_ni && !mem_cs1_ni)    tgt = TGT_RAM;
    else if (!per_cs_ni && per_cs_i)   tgt = TGT_REG;
    else                               tgt = TGT_NONE;
  end

  hbi_lane_steer #(.DW(DW)) u_lane (
    .wide_i(wide_i), .a0_i(eff_addr[0]), .bhe_ni(bhe_ni),
    .data_i(data_i),
    .rdata_i(tgt == TGT_RAM ? ram_rdata_i : reg_rdata_i),
    .be_o(be_c), .wdata_o(wdata_c), .rd_out_o(rd_out), .lane_en_o(lane_en)
  );

  assign data_o    = rd_out;
  assign data_oe_o = (rd_act && tgt != TGT_NONE) ? lane_en : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ram_rd_o   <= 1'b0;
      ram_wr_o   <= 1'b0;
      reg_rd_o   <= 1'b0;
      reg_wr_o   <= 1'b0;
      ram_addr_o <= '0;
      reg_addr_o <= '0;
      be_o       <= '0;
      wdata_o    <= '0;
    end else begin
      // write wins if both edges coincide
      ram_wr_o <= wr_pulse && tgt == TGT_RAM;
      reg_wr_o <= wr_pulse && tgt == TGT_REG;
      ram_rd_o <= !wr_pulse && rd_pulse && tgt == TGT_RAM;
      reg_rd_o <= !wr_pulse && rd_pulse && tgt == TGT_REG;
      if ((rd_pulse || wr_pulse) && tgt != TGT_NONE) begin
        ram_addr_o <= eff_addr[RAM_AW:1];
        reg_addr_o <= eff_addr[REG_AW:1];
        be_o       <= be_c;
        wdata_o    <= wdata_c;
      end
    end
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wide_i,
  input logic          mux_i,
  input logic          ale_lo_i,
  input logic          ale_hi_i,
  input logic [AW-1:0] addr_o,
  input logic [1:0]    data_oe_o,
  input logic          mem_cs0_ni,
  input logic          mem_cs1_ni,
  input logic          per_cs_ni,
  input logic          per_cs_i,
  input logic          ram_rd_o,
  input logic          ram_wr_o,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic [1:0]    be_o
);
  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_rd_o, ram_wr_o, reg_rd_o, reg_wr_o}));

  p_single_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_rd_o || ram_wr_o || reg_rd_o || reg_wr_o) |=>
      !(ram_rd_o || ram_wr_o || reg_rd_o || reg_wr_o));

  p_oe_needs_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != 2'b00) |->
      ((!mem_cs0_ni && !mem_cs1_ni) || (!per_cs_ni && per_cs_i)));

  p_narrow_lane_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> !data_oe_o[1]);

  p_narrow_be_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && (ram_wr_o || reg_wr_o)) |-> $onehot(be_o));

  p_latch_hold_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_lo_i && $past(!ale_lo_i)) |-> $stable(addr_o[AW/2-1:0]));

  p_latch_hold_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_hi_i && $past(!ale_hi_i)) |-> $stable(addr_o[AW-1:AW/2]));
endmodule

bind host_bus_if hbi_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/host_bus_if_bench.sv
`timescale 1ns/1ps
module host_bus_if_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic moto, pol, wide, mux, sa, sb, alo, ahi, cs0, cs1, pcsn, pcs, bhen;
  logic [15:0] ain, aout, din, dout, ramrd, regrd, wdat;
  logic [1:0] doe, be;
  logic aoe, rrd, rwr, grd, gwr;
  logic [9:0] raddr;
  logic [5:0] gaddr;

  int checks = 0, fails = 0;

  host_bus_if u_host_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .mode_moto_i(moto), .ds_pol_i(pol),
    .wide_i(wide), .mux_i(mux), .strb_a_i(sa), .strb_b_i(sb),
    .ale_lo_i(alo), .ale_hi_i(ahi), .addr_i(ain), .addr_o(aout),
    .addr_oe_o(aoe), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .mem_cs0_ni(cs0), .mem_cs1_ni(cs1), .per_cs_ni(pcsn), .per_cs_i(pcs),
    .bhe_ni(bhen), .ram_rd_o(rrd), .ram_wr_o(rwr), .ram_addr_o(raddr),
    .reg_rd_o(grd), .reg_wr_o(gwr), .reg_addr_o(gaddr), .be_o(be),
    .wdata_o(wdat), .ram_rdata_i(ramrd), .reg_rdata_i(regrd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // tgt: 0 none, 1 RAM, 2 register
  task automatic access(input bit m, p, w, x, wr, input int tgt,
                        input logic [15:0] a, d, input bit bh);
    int n = 0;
    logic [3:0] kind = '0;
    logic [9:0] c_ra = '0;
    logic [5:0] c_ga = '0;
    logic [1:0] c_be = '0;
    logic [15:0] c_wd = '0, rsrc, exp_do;
    logic [1:0] exp_be, exp_oe;
    logic [15:0] exp_wd;
    @(negedge clk);
    moto = m; pol = p; wide = w; mux = x;
    sa = m ? ~p : 1'b1; sb = 1'b1;
    cs0 = (tgt != 1); cs1 = (tgt != 1);
    pcsn = (tgt != 2); pcs = (tgt == 2);
    bhen = bh;
    if (x) begin
      ain = 16'hDEAD; alo = 1'b1; ahi = 1'b1; din = a;
      repeat (2) @(negedge clk);
      alo = 1'b0; ahi = 1'b0;
      @(negedge clk);
      din = wr ? d : 16'h5A5A;
      @(negedge clk);
      chk(aout == a && aoe, "R6 latched address", {15'd0, aoe, aout}, {16'd1, a});
    end else begin
      alo = 1'b1; ahi = 1'b1; ain = a; din = d;
      @(negedge clk);
      chk(aoe == 1'b0, "R7 address drive off", aoe, 0);
    end
    if (m && wr) begin sb = 1'b0; @(negedge clk); end
    if (m) sa = p;
    else if (wr) sb = 1'b0;
    else sa = 1'b0;
    rsrc = (tgt == 1) ? ramrd : regrd;
    exp_do = w ? rsrc : {8'h00, (a[0] ? rsrc[15:8] : rsrc[7:0])};
    exp_oe = (tgt == 0 || wr) ? 2'b00 : (w ? {~bh, ~a[0]} : 2'b01);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (x && c == 5 && !wr) begin
        din = 16'hFFFF;
        @(negedge clk);
        chk(aout == a, "R6 latch holds", aout, a);
      end
      if (rrd | rwr | grd | gwr) begin
        n++;
        kind = {rrd, rwr, grd, gwr};
        c_ra = raddr; c_ga = gaddr; c_be = be; c_wd = wdat;
      end
      if (c == 3) begin
        chk(doe == exp_oe, "R10 lane drive enable", doe, exp_oe);
        if (!wr && tgt != 0)
          chk(dout == exp_do, w ? "R8 wide read data" : "R9 narrow read data", dout, exp_do);
      end
    end
    if (m) sa = ~p; else begin sa = 1'b1; sb = 1'b1; end
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rrd | rwr | grd | gwr) n++;
    end
    sb = 1'b1;
    chk(n == (tgt == 0 ? 0 : 1), "R4/R5 pulse count", n, (tgt == 0 ? 0 : 1));
    if (tgt != 0 && n == 1) begin
      logic [3:0] ek;
      ek = (tgt == 1) ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
      chk(kind == ek, m ? (p ? "R3 active-high strobe kind" : "R2 strobe kind")
                        : "R1 strobe kind", kind, ek);
      if (tgt == 1) chk(c_ra == a[10:1], "R5 RAM word address", c_ra, a[10:1]);
      else          chk(c_ga == a[6:1], "R5 register address", c_ga, a[6:1]);
      exp_be = w ? {~bh, ~a[0]} : (a[0] ? 2'b10 : 2'b01);
      chk(c_be == exp_be, w ? "R8 byte enables" : "R9 byte enables", c_be, exp_be);
      if (wr) begin
        exp_wd = w ? d : {d[7:0], d[7:0]};
        chk(c_wd == exp_wd, w ? "R8 write data" : "R9 write data", c_wd, exp_wd);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    moto = 0; pol = 0; wide = 1; mux = 0; sa = 1; sb = 1; alo = 1; ahi = 1;
    cs0 = 1; cs1 = 1; pcsn = 1; pcs = 0; bhen = 1; ain = '0; din = '0;
    ramrd = 16'hA5C3; regrd = 16'h3C96;
    repeat (3) @(negedge clk);
    chk({rrd, rwr, grd, gwr} == 4'b0 && aout == 16'h0, "R11 reset state",
        {rrd, rwr, grd, gwr, aout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          for (int x = 0; x < 2; x++)
            for (int wr = 0; wr < 2; wr++)
              for (int t = 0; t < 3; t++)
                for (int i = 0; i < 4; i++) begin
                  logic [15:0] a, d;
                  a = 16'(i * 16'h1357 + 16'h0421 + m * 16'h0B0 + t * 3 + x);
                  d = 16'(16'hC0DE ^ (i * 16'h0F1E) ^ (w << 4) ^ (wr << 9));
                  access(m[0], p[0], w[0], x[0], wr[0], t, a, d, a[1] ^ i[0]);
                end
    summary();
  end
endmodule